// File: doc/BRIEF.md
# Retained Scratchpad with Reset-Cause Capture

This block is a small always-on register bank. It holds three 32-bit scratch words, one write-once-per-boot protected word guarded by a lock bit, and a status word of sticky reset-cause flags. Everything it stores is kept across the chip's always-on soft reset, sleep entry and brownout recovery. Only the power-on reset input returns it to zero. Firmware uses it to pass facts from one boot to the next: why the chip restarted, which error was last seen, and which debug grants were approved during boot.

Access is through a single-cycle memory-mapped request port. Each request carries a privilege flag, and the port also sees a boot-done input. The response comes one clock after the request, with an acknowledge, read data, an error flag for unmapped offsets, and a violation flag for writes that are refused. Reset-cause sources deliver one-cycle pulses, which are latched as sticky flags. Three of these flags, the two voltage-fault flags and the brownout flag, are recorded only while the matching protection input is low. Software clears all flags at once with a write-one command bit.

Top module: `aon_scratch_bank`

## Requirements
- R1: Every request with `req_valid` high is answered by `rsp_ack` high for exactly one cycle, on the clock after the request. The general words at offsets 0x0 and 0x1000 can be written by any requester and read back unchanged.
- R2: A write to the protected word at offset 0x8 takes effect only if `req_priv` is 1, `boot_done` is 0 and the lock is clear.
- R3: Bit 0 of a write to the lock at offset 0xC sets the lock, under the same conditions as R2. A read of 0xC returns the lock in bit 0. While the lock is set, writes to 0x8 and 0xC have no effect until power-on reset.
- R4: A refused write to 0x8 or 0xC is still acknowledged, raises `rsp_viol` for that one response cycle, and leaves the stored value unchanged.
- R5: A one-cycle pulse on `cause_pulse[i]` sets bit i of the cause word at offset 0x4, and the bit stays set. The flags are: 0 reset pin, 1 power-on, 2 low-voltage fault, 3 high-voltage fault, 4 brownout, 5 core self reset, 6 debug request, 7 application-core watchdog, 8 host reset, 9 sleep wake, 10 core stop, 11 control-core watchdog.
- R6: Flags 2, 3 and 4 are recorded only while `prot_en[0]`, `prot_en[1]` and `prot_en[2]`, respectively, are 0.
- R7: A write to 0x4 with bit 16 set clears all cause flags. A write with bit 16 clear changes nothing. A pulse that arrives in the same cycle as a clear leaves its flag set.
- R8: The cause flags cannot be written. Bits 12 to 31 of the cause word, including the clear bit 16, and bits 1 to 31 of the lock word always read 0.
- R9: A read or write at any other offset returns read data 0 and raises `rsp_err`, and changes no stored state.
- R10: While `soc_rst_n` is low, requests get no response. The stored words, the lock and the cause flags are unchanged by that reset, and only `por_n` low clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all storage |
| soc_rst_n | input | 1 | Always-on soft reset, active low; resets only the response path |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Byte offset of the access |
| req_wdata | input | DATA_W (32) | Write data |
| req_priv | input | 1 | Requester is privileged |
| boot_done | input | 1 | High once boot has finished; closes the protected write window |
| cause_pulse | input | N_CAUSE (12) | One-cycle reset-source pulses |
| prot_en | input | 3 | Protection enables for the low-voltage, high-voltage and brownout flags |
| rsp_ack | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | DATA_W (32) | Read data |
| rsp_err | output | 1 | Unmapped offset |
| rsp_viol | output | 1 | Protected write refused |

## Verification
The protected-word gating is tested with each refusing condition on its own: an unprivileged requester, boot done, and lock set. Each must raise a violation and keep the old value, and only the all-clear combination may write, which tells apart the terms of the permission check. Cause pulses are sent with protection enabled and then disabled, so that guarded flags are distinguished from unguarded ones. A clear and a pulse are sent in the same cycle, and writes with bit 16 low are sent, to show that set wins and that the command bit really gates the clear. A random mix of all offsets, privilege levels, pulses and protection settings is compared with a bench model, and a soft reset in the middle followed by a power-on reset at the end separates what the block retains from what it clears.

// File: rtl/scr_pkg.sv
package scr_pkg;
   localparam logic [31:0] OFF_LINE1 = 32'h0000_0000;
   localparam logic [31:0] OFF_CAUSE = 32'h0000_0004;
   localparam logic [31:0] OFF_LINE0 = 32'h0000_0008;
   localparam logic [31:0] OFF_LOCK  = 32'h0000_000C;
   localparam logic [31:0] OFF_LINE2 = 32'h0000_1000;

   // cause indices whose capture depends on a protection enable
   localparam int IDX_LOWV  = 2;
   localparam int IDX_HIGHV = 3;
   localparam int IDX_BROWN = 4;

   typedef struct packed {
      logic line1;
      logic cause;
      logic line0;
      logic lock;
      logic line2;
      logic none;
   } scr_sel_t;
endpackage

// File: rtl/scr_decode.sv
module scr_decode
   import scr_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] addr,
   output scr_sel_t          sel
);
   always_comb begin
      sel       = '0;
      sel.line1 = (addr == OFF_LINE1[ADDR_W-1:0]);
      sel.cause = (addr == OFF_CAUSE[ADDR_W-1:0]);
      sel.line0 = (addr == OFF_LINE0[ADDR_W-1:0]);
      sel.lock  = (addr == OFF_LOCK[ADDR_W-1:0]);
      sel.line2 = (addr == OFF_LINE2[ADDR_W-1:0]);
      sel.none  = ~(sel.line1 | sel.cause | sel.line0 | sel.lock | sel.line2);
   end
endmodule

// File: rtl/scr_word.sv
module scr_word #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/scr_cause_cap.sv
module scr_cause_cap
   import scr_pkg::*;
#(
   parameter int N_CAUSE = 12
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic [N_CAUSE-1:0] pulse,
   input  logic [2:0]         prot_en,
   input  logic               clr,
   output logic [N_CAUSE-1:0] flags
);
   for (genvar i = 0; i < N_CAUSE; i++) begin : g_bit
      logic hit;
      if (i == IDX_LOWV) begin : g_lowv
         assign hit = pulse[i] & ~prot_en[0];
      end else if (i == IDX_HIGHV) begin : g_highv
         assign hit = pulse[i] & ~prot_en[1];
      end else if (i == IDX_BROWN) begin : g_brown
         assign hit = pulse[i] & ~prot_en[2];
      end else begin : g_plain
         assign hit = pulse[i];
      end

      // set has priority over clear
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) flags[i] <= 1'b0;
         else        flags[i] <= hit | (flags[i] & ~clr);
      end
   end
endmodule

// File: rtl/aon_scratch_bank.sv
module aon_scratch_bank
   import scr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 13,
   parameter int N_CAUSE = 12,
   parameter int CLR_BIT = 16
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               soc_rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               req_priv,
   input  logic               boot_done,
   input  logic [N_CAUSE-1:0] cause_pulse,
   input  logic [2:0]         prot_en,
   output logic               rsp_ack,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               rsp_err,
   output logic               rsp_viol
);
   localparam int PAD_CAUSE = DATA_W - N_CAUSE;
   localparam int PAD_LOCK  = DATA_W - 1;

   if (ADDR_W < 13 || ADDR_W > 31) begin : g_bad_addr
      $error("ADDR_W must lie in 13..31 to reach every offset");
   end
   if (CLR_BIT >= DATA_W || N_CAUSE > CLR_BIT) begin : g_bad_clr
      $error("clear bit must sit above the cause flags and inside the word");
   end
   if (N_CAUSE <= IDX_BROWN) begin : g_bad_cause
      $error("N_CAUSE too small for the guarded flags");
   end

   scr_sel_t            sel;
   logic                acc, wr, window_ok, reject, clr_cmd;
   logic                we_l0, we_l1, we_l2, we_lock;
   logic [DATA_W-1:0]   line0_q, line1_q, line2_q, rd_d;
   logic                lock_q;
   logic [N_CAUSE-1:0]  cause_q;

   scr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(req_addr), .sel(sel));

   assign acc       = req_valid & soc_rst_n;
   assign wr        = acc & req_write;
   assign window_ok = req_priv & ~boot_done & ~lock_q;
   assign we_l1     = wr & sel.line1;
   assign we_l2     = wr & sel.line2;
   assign we_l0     = wr & sel.line0 & window_ok;
   assign we_lock   = wr & sel.lock & window_ok;
   assign reject    = wr & (sel.line0 | sel.lock) & ~window_ok;
   assign clr_cmd   = wr & sel.cause & req_wdata[CLR_BIT];

   scr_word #(.W(DATA_W)) u_line0 (.clk(clk), .por_n(por_n), .we(we_l0),
                                   .d(req_wdata), .q(line0_q));
   scr_word #(.W(DATA_W)) u_line1 (.clk(clk), .por_n(por_n), .we(we_l1),
                                   .d(req_wdata), .q(line1_q));
   scr_word #(.W(DATA_W)) u_line2 (.clk(clk), .por_n(por_n), .we(we_l2),
                                   .d(req_wdata), .q(line2_q));
   scr_word #(.W(1))      u_lock  (.clk(clk), .por_n(por_n), .we(we_lock),
                                   .d(req_wdata[0]), .q(lock_q));

   scr_cause_cap #(.N_CAUSE(N_CAUSE)) u_cause (
      .clk(clk), .por_n(por_n), .pulse(cause_pulse), .prot_en(prot_en),
      .clr(clr_cmd), .flags(cause_q));

   always_comb begin
      rd_d = '0;
      if (sel.line1)      rd_d = line1_q;
      else if (sel.cause) rd_d = {{PAD_CAUSE{1'b0}}, cause_q};
      else if (sel.line0) rd_d = line0_q;
      else if (sel.lock)  rd_d = {{PAD_LOCK{1'b0}}, lock_q};
      else if (sel.line2) rd_d = line2_q;
   end

   // response path is the only state the soft reset touches
   always_ff @(posedge clk or negedge soc_rst_n) begin
      if (!soc_rst_n) begin
         rsp_ack   <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_viol  <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_ack   <= acc;
         rsp_err   <= acc & sel.none;
         rsp_viol  <= reject;
         rsp_rdata <= (acc & ~req_write) ? rd_d : '0;
      end
   end
endmodule

// File: rtl/scr_checker.sv
module scr_checker
   import scr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int N_CAUSE = 12
) (
   input logic               clk,
   input logic               por_n,
   input logic               soc_rst_n,
   input logic               req_valid,
   input logic               rsp_ack,
   input logic               rsp_err,
   input logic               rsp_viol,
   input logic [DATA_W-1:0]  rsp_rdata,
   input logic               lock_q,
   input logic [DATA_W-1:0]  line0_q,
   input logic [N_CAUSE-1:0] cause_q,
   input logic [N_CAUSE-1:0] cause_pulse,
   input logic [2:0]         prot_en,
   input logic               clr_cmd
);
   logic [N_CAUSE-1:0] guard, eff;
   always_comb begin
      guard            = '0;
      guard[IDX_LOWV]  = prot_en[0];
      guard[IDX_HIGHV] = prot_en[1];
      guard[IDX_BROWN] = prot_en[2];
      eff              = cause_pulse & ~guard;
   end

   AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n || !soc_rst_n)
      req_valid |=> rsp_ack); // R1
   AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!por_n || !soc_rst_n)
      !req_valid |=> !rsp_ack); // R1
   AST_VIOL_WITH_ACK: assert property (@(posedge clk) disable iff (!por_n || !soc_rst_n)
      rsp_viol |-> rsp_ack); // R4
   AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> lock_q); // R3
   AST_LOCKED_LINE_HELD: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> $stable(line0_q)); // R3
   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      !clr_cmd |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R5
   AST_PULSE_CAPTURED: assert property (@(posedge clk) disable iff (!por_n)
      (|eff) |=> ((cause_q & $past(eff)) == $past(eff))); // R7
   AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n || !soc_rst_n)
      rsp_err |-> (rsp_rdata == '0)); // R9
endmodule

bind aon_scratch_bank scr_checker #(.DATA_W(DATA_W), .N_CAUSE(N_CAUSE)) u_chk (
   .clk(clk), .por_n(por_n), .soc_rst_n(soc_rst_n), .req_valid(req_valid),
   .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_viol(rsp_viol),
   .rsp_rdata(rsp_rdata), .lock_q(lock_q), .line0_q(line0_q),
   .cause_q(cause_q), .cause_pulse(cause_pulse), .prot_en(prot_en),
   .clr_cmd(clr_cmd));

// File: tb/aon_scratch_bank_test.sv
module aon_scratch_bank_test;
   logic        clk = 1'b0;
   logic        por_n = 1'b0, soc_rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, boot_done = 1'b0;
   logic [12:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [11:0] cause_pulse = '0;
   logic [2:0]  prot_en = '0;
   logic        rsp_ack, rsp_err, rsp_viol;
   logic [31:0] rsp_rdata;

   int n_chk = 0, n_bad = 0;
   logic        finished = 1'b0;

   logic [31:0] m_l0 = '0, m_l1 = '0, m_l2 = '0;
   logic        m_lock = 1'b0;
   logic [11:0] m_cause = '0;

   always #5 clk = ~clk;

   aon_scratch_bank uut (
      .clk(clk), .por_n(por_n), .soc_rst_n(soc_rst_n), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_priv(req_priv), .boot_done(boot_done), .cause_pulse(cause_pulse),
      .prot_en(prot_en), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .rsp_viol(rsp_viol));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] guard_of(logic [2:0] p);
      logic [11:0] g = '0;
      g[2] = p[0]; g[3] = p[1]; g[4] = p[2];
      return g;
   endfunction

   function automatic bit mapped(logic [12:0] a);
      return a == 13'h0 || a == 13'h4 || a == 13'h8 || a == 13'hC || a == 13'h1000;
   endfunction

   function automatic logic [31:0] exp_rd(logic [12:0] a);
      case (a)
         13'h0000: return m_l1;
         13'h0004: return {20'b0, m_cause};
         13'h0008: return m_l0;
         13'h000C: return {31'b0, m_lock};
         13'h1000: return m_l2;
         default:  return '0;
      endcase
   endfunction

   // one bus access, with an optional cause pulse in the same cycle
   task automatic access(string tag, logic w, logic [12:0] a, logic [31:0] d,
                         logic priv, logic [11:0] pls);
      logic [31:0] e_rd;
      logic        e_viol, ok;
      e_rd   = exp_rd(a);
      ok     = priv && !boot_done && !m_lock;
      e_viol = w && (a == 13'h8 || a == 13'hC) && !ok;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      req_priv = priv; cause_pulse = pls;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; cause_pulse = '0;
      if (w) begin
         if (a == 13'h0) m_l1 = d;
         if (a == 13'h1000) m_l2 = d;
         if (a == 13'h8 && ok) m_l0 = d;
         if (a == 13'hC && ok) m_lock = d[0];
         if (a == 13'h4 && d[16]) m_cause = '0;
      end
      m_cause |= pls & ~guard_of(prot_en);
      chk({tag, " ack"}, {31'b0, rsp_ack}, 32'd1);
      chk({tag, " err"}, {31'b0, rsp_err}, {31'b0, !mapped(a)});
      chk({tag, " viol"}, {31'b0, rsp_viol}, {31'b0, e_viol});
      if (!w) chk({tag, " rdata"}, rsp_rdata, e_rd);
   endtask

   task automatic rd(string tag, logic [12:0] a);
      access(tag, 1'b0, a, '0, 1'b0, '0);
   endtask

   task automatic pulse(logic [11:0] p);
      @(negedge clk); cause_pulse = p;
      @(negedge clk); cause_pulse = '0;
      m_cause |= p & ~guard_of(prot_en);
   endtask

   task automatic read_all(string tag);
      rd(tag, 13'h0); rd(tag, 13'h4); rd(tag, 13'h8); rd(tag, 13'hC); rd(tag, 13'h1000);
   endtask

   task automatic do_por();
      @(negedge clk); por_n = 1'b0; soc_rst_n = 1'b0;
      m_l0 = '0; m_l1 = '0; m_l2 = '0; m_lock = 1'b0; m_cause = '0;
      repeat (2) @(negedge clk);
      por_n = 1'b1; soc_rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'h5eed);
      repeat (3) @(negedge clk);
      por_n = 1'b1; soc_rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset ack", {31'b0, rsp_ack}, 32'd0);
      chk("R4 reset viol", {31'b0, rsp_viol}, 32'd0);
      read_all("R10 por clears");

      // R1 general words
      access("R1 write line1", 1'b1, 13'h0, 32'hA5A5_1234, 1'b0, '0);
      access("R1 write line2", 1'b1, 13'h1000, 32'h0BAD_F00D, 1'b0, '0);
      rd("R1 read line1", 13'h0);
      rd("R1 read line2", 13'h1000);

      // R2 / R4 protected word gating
      access("R4 unpriv line0", 1'b1, 13'h8, 32'h1111_2222, 1'b0, '0);
      rd("R2 line0 untouched", 13'h8);
      boot_done = 1'b1;
      access("R4 after boot line0", 1'b1, 13'h8, 32'h3333_4444, 1'b1, '0);
      access("R4 after boot lock", 1'b1, 13'hC, 32'h1, 1'b1, '0);
      rd("R2 line0 after boot", 13'h8);
      rd("R3 lock after boot", 13'hC);
      boot_done = 1'b0;
      access("R2 priv line0", 1'b1, 13'h8, 32'hCAFE_0001, 1'b1, '0);
      rd("R2 read line0", 13'h8);

      // R5 / R6 cause capture
      prot_en = 3'b000;
      pulse(12'h821);
      rd("R5 flags 0 5 11", 13'h4);
      pulse(12'h000);
      rd("R5 flags stay", 13'h4);
      prot_en = 3'b111;
      pulse(12'h01C);
      rd("R6 guarded ignored", 13'h4);
      prot_en = 3'b010;
      pulse(12'h01C);
      rd("R6 unguarded recorded", 13'h4);
      prot_en = 3'b000;
      pulse(12'h7FF);

      // R7 / R8 clear and write-ignore
      access("R8 write flags no clear", 1'b1, 13'h4, 32'h0000_0FFF, 1'b1, '0);
      rd("R8 flags not writable", 13'h4);
      access("R7 write without bit16", 1'b1, 13'h4, 32'hFFFE_0000, 1'b1, '0);
      rd("R7 no clear without bit16", 13'h4);
      access("R7 clear", 1'b1, 13'h4, 32'h0001_0000, 1'b0, '0);
      rd("R7 cleared", 13'h4);
      pulse(12'h003);
      access("R7 clear with pulse", 1'b1, 13'h4, 32'hFFFF_FFFF, 1'b0, 12'h400);
      rd("R7 set wins", 13'h4);
      chk("R8 upper cause bits zero", rsp_rdata & 32'hFFFF_F000, 32'h0);

      // R9 unmapped
      rd("R9 read 0x10", 13'h10);
      rd("R9 read misaligned", 13'h2);
      access("R9 write 0x1004", 1'b1, 13'h1004, 32'hFFFF_FFFF, 1'b1, '0);
      read_all("R9 state unchanged");

      // R3 lock
      access("R3 set lock", 1'b1, 13'hC, 32'hFFFF_FFFF, 1'b1, '0);
      rd("R3 lock reads one", 13'hC);
      chk("R8 lock upper bits zero", rsp_rdata, 32'h1);
      access("R3 locked line0", 1'b1, 13'h8, 32'hDEAD_BEEF, 1'b1, '0);
      access("R3 locked unlock attempt", 1'b1, 13'hC, 32'h0, 1'b1, '0);
      rd("R3 line0 held", 13'h8);
      rd("R3 lock held", 13'hC);

      // R10 power-on clears lock and all storage
      do_por();
      read_all("R10 por after lock");
      access("R3 lock released line0", 1'b1, 13'h8, 32'h0000_00AA, 1'b1, '0);
      rd("R3 line0 writable again", 13'h8);

      // random phase
      for (int i = 0; i < 500; i++) begin
         logic [12:0] a;
         logic [11:0] p;
         case ($urandom % 8)
            0: a = 13'h0;    1: a = 13'h4;    2: a = 13'h8;   3: a = 13'hC;
            4: a = 13'h1000; 5: a = 13'h10;   6: a = 13'h8;   default: a = 13'h4;
         endcase
         p = ($urandom % 3 == 0) ? 12'($urandom) : 12'h0;
         prot_en = 3'($urandom);
         if (a == 13'hC && ($urandom % 8 != 0)) begin
            access("R3 random lock", 1'b0, a, '0, 1'b1, p);
         end else begin
            access("R5 random", 1'($urandom), a, (($urandom % 4 == 0) ? 32'h0001_0000 : 0) ^ $urandom,
                   1'($urandom), p);
         end
      end
      read_all("R5 random end");

      // R10 soft reset keeps everything
      access("R10 prep line1", 1'b1, 13'h0, 32'h7777_8888, 1'b0, '0);
      prot_en = 3'b000;
      @(negedge clk);
      soc_rst_n = 1'b0;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0; req_wdata = 32'h0;
      cause_pulse = 12'h020;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; cause_pulse = '0;
      m_cause |= 12'h020;
      chk("R10 no ack in soft reset", {31'b0, rsp_ack}, 32'd0);
      @(negedge clk);
      soc_rst_n = 1'b1;
      @(negedge clk);
      read_all("R10 soft reset retains");

      do_por();
      read_all("R10 final por");

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule